// File: doc/BRIEF.md
# Stereo Frame Interleaver with Shutter Sync

Two cameras each deliver 640x480 frames at 30 per second into a pair of frame stores. This block reads those stores in step with a display timing generator that runs at 60 frames per second. It chooses one store per output frame and switches to the other store on the next frame. The display therefore shows the left view and the right view in turn, and each camera frame appears once in every pair of output frames.

A shutter-glasses drive signal follows the eye currently being shown. That signal is allowed to change only at a frame boundary, which falls inside vertical blanking, so each lens opens for exactly the frame meant for it.

The block takes three timing inputs: a frame-start pulse, a line-start pulse and an active-video level. From these it forms a linear read address of the form row times the active width plus column. It drives a read enable to exactly one store at a time. After the stores' fixed read latency it forwards the returned pixel, and it outputs zero during blanking.

Top module: `stereo_interleaver`

## Requirements
- R1: While reset is asserted and directly after it, eye_sel is 1, glasses is at its idle level (1 when GLASS_INV is 0), both read enables are 0, pix_valid is 0 and pix_out is 0.
- R2: eye_sel inverts on the clock edge that samples frame_start high and holds its value on every other edge. An eye_sel of 0 means the left view is shown and 1 means the right view.
- R3: glasses equals eye_sel when GLASS_INV is 0 and its inverse when GLASS_INV is 1. It changes only on the edge after a frame_start pulse.
- R4: In a cycle with active high, rd_en_left is high when eye_sel is 0 and rd_en_right is high when eye_sel is 1. With active low, both enables are low. The two enables are never high together.
- R5: During an active cycle rd_addr is row*H_ACT + col. Here col is the number of active cycles seen so far in the current line, and row is the number of lines so far in the frame that held at least one active cycle. A frame_start pulse sets both row and col to 0.
- R6: A line_start pulse sets col to 0. It advances row only if the line that just ended held at least one active cycle, so a line with no active cycles leaves the address unchanged.
- R7: col stops at H_ACT-1 and row stops at V_ACT-1, so rd_addr never goes beyond H_ACT*V_ACT-1.
- R8: Exactly RD_LAT cycles after an active cycle, pix_valid is high and pix_out carries the data returned by the store that was enabled in that cycle.
- R9: While pix_valid is low, pix_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse at the start of each output frame, during vertical blanking |
| line_start | input | 1 | One-cycle pulse at the start of each line, outside active video |
| active | input | 1 | High for each visible pixel cycle |
| left_rd_data | input | PIX_W | Read data from the left frame store, RD_LAT cycles after its enable |
| right_rd_data | input | PIX_W | Read data from the right frame store, RD_LAT cycles after its enable |
| rd_addr | output | ADDR_W | Read address shared by both stores |
| rd_en_left | output | 1 | Read enable for the left store |
| rd_en_right | output | 1 | Read enable for the right store |
| pix_out | output | PIX_W | Selected pixel, zero outside valid cycles |
| pix_valid | output | 1 | pix_out holds a visible pixel |
| eye_sel | output | 1 | Eye being shown: 0 left, 1 right |
| glasses | output | 1 | Shutter-glasses drive |

## Verification
The assertions assume three things about the timing inputs: frame_start and line_start are single-cycle pulses, they never occur in a cycle where active is high, and every frame starts with a frame_start pulse. The stimulus keeps to these rules. Each pulse is given its own blanking cycle, and a frame_start is always issued before any pixel cycle. The directed section still pushes the counters past their limits by sending too many pixels in a line and too many lines in a frame, and it also sends lines that hold no active cycles.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
   typedef enum logic {
      EYE_LEFT  = 1'b0,
      EYE_RIGHT = 1'b1
   } eye_e;

   localparam int unsigned MAX_RD_LAT = 4;

   function automatic logic eye_is_left(input logic eye);
      return eye == EYE_LEFT;
   endfunction
endpackage

// File: rtl/sfi_eye_ctrl.sv
module sfi_eye_ctrl #(
   parameter bit GLASS_INV = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   output logic eye_sel,
   output logic glasses
);
   import sfi_pkg::*;

   eye_e eye_q;
   logic glasses_q;
   logic eye_nxt;

   assign eye_nxt = frame_start ? ~eye_q : eye_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eye_q <= EYE_RIGHT;
      else        eye_q <= eye_e'(eye_nxt);
   end

   generate
      if (GLASS_INV) begin : g_inv
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) glasses_q <= ~EYE_RIGHT;
            else        glasses_q <= ~eye_nxt;
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) glasses_q <= EYE_RIGHT;
            else        glasses_q <= eye_nxt;
         end
      end
   endgenerate

   assign eye_sel = eye_q;
   assign glasses = glasses_q;
endmodule

// File: rtl/sfi_addr_gen.sv
module sfi_addr_gen #(
   parameter int unsigned H_ACT  = 640,
   parameter int unsigned V_ACT  = 480,
   parameter int unsigned ADDR_W = $clog2(H_ACT * V_ACT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              active,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned COL_W = $clog2(H_ACT);
   localparam int unsigned ROW_W = $clog2(V_ACT);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_ACT - 1);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_ACT - 1);

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         seen_q <= 1'b0;
      end else if (frame_start) begin
         col_q  <= '0;
         row_q  <= '0;
         seen_q <= 1'b0;
      end else if (line_start) begin
         col_q  <= '0;
         seen_q <= 1'b0;
         if (seen_q && row_q != ROW_LAST) row_q <= row_q + 1'b1;
      end else if (active) begin
         seen_q <= 1'b1;
         if (col_q != COL_LAST) col_q <= col_q + 1'b1;
      end
   end

   assign addr = ADDR_W'(row_q) * ADDR_W'(H_ACT) + ADDR_W'(col_q);
endmodule

// File: rtl/sfi_pix_path.sv
module sfi_pix_path #(
   parameter int unsigned PIX_W  = 24,
   parameter int unsigned RD_LAT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             eye_sel,
   input  logic [PIX_W-1:0] left_data,
   input  logic [PIX_W-1:0] right_data,
   output logic [PIX_W-1:0] pix,
   output logic             valid
);
   import sfi_pkg::*;

   logic [RD_LAT-1:0] act_sr;
   logic [RD_LAT-1:0] eye_sr;

   generate
      if (RD_LAT == 1) begin : g_lat1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_sr <= '0;
               eye_sr <= '0;
            end else begin
               act_sr <= active;
               eye_sr <= eye_sel;
            end
         end
      end else begin : g_latn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_sr <= '0;
               eye_sr <= '0;
            end else begin
               act_sr <= {act_sr[RD_LAT-2:0], active};
               eye_sr <= {eye_sr[RD_LAT-2:0], eye_sel};
            end
         end
      end
   endgenerate

   assign valid = act_sr[RD_LAT-1];

   always_comb begin
      if (!valid)                          pix = '0;
      else if (eye_is_left(eye_sr[RD_LAT-1])) pix = left_data;
      else                                 pix = right_data;
   end
endmodule

// File: rtl/stereo_interleaver.sv
module stereo_interleaver #(
   parameter int unsigned H_ACT     = 640,
   parameter int unsigned V_ACT     = 480,
   parameter int unsigned PIX_W     = 24,
   parameter int unsigned RD_LAT    = 1,
   parameter bit          GLASS_INV = 1'b0,
   parameter int unsigned ADDR_W    = $clog2(H_ACT * V_ACT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              active,
   input  logic [PIX_W-1:0]  left_rd_data,
   input  logic [PIX_W-1:0]  right_rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_en_left,
   output logic              rd_en_right,
   output logic [PIX_W-1:0]  pix_out,
   output logic              pix_valid,
   output logic              eye_sel,
   output logic              glasses
);
   import sfi_pkg::*;

   generate
      if (H_ACT < 2 || V_ACT < 2) begin : g_bad_geom
         $error("stereo_interleaver: H_ACT and V_ACT must be at least 2");
      end
      if (RD_LAT < 1 || RD_LAT > MAX_RD_LAT) begin : g_bad_lat
         $error("stereo_interleaver: RD_LAT out of range");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("stereo_interleaver: PIX_W must be positive");
      end
      if ((1 << ADDR_W) < H_ACT * V_ACT) begin : g_bad_addr
         $error("stereo_interleaver: ADDR_W too narrow");
      end
   endgenerate

   logic eye_w;

   sfi_eye_ctrl #(.GLASS_INV(GLASS_INV)) eye_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .eye_sel     (eye_w),
      .glasses     (glasses)
   );

   sfi_addr_gen #(.H_ACT(H_ACT), .V_ACT(V_ACT), .ADDR_W(ADDR_W)) addr_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_start  (line_start),
      .active      (active),
      .addr        (rd_addr)
   );

   sfi_pix_path #(.PIX_W(PIX_W), .RD_LAT(RD_LAT)) pix_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .eye_sel    (eye_w),
      .left_data  (left_rd_data),
      .right_data (right_rd_data),
      .pix        (pix_out),
      .valid      (pix_valid)
   );

   assign rd_en_left  = active &  eye_is_left(eye_w);
   assign rd_en_right = active & ~eye_is_left(eye_w);
   assign eye_sel     = eye_w;
endmodule

// File: rtl/sfi_checker.sv
module sfi_checker #(
   parameter int unsigned H_ACT     = 640,
   parameter int unsigned V_ACT     = 480,
   parameter int unsigned PIX_W     = 24,
   parameter int unsigned RD_LAT    = 1,
   parameter bit          GLASS_INV = 1'b0,
   parameter int unsigned ADDR_W    = $clog2(H_ACT * V_ACT)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              active,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_en_left,
   input logic              rd_en_right,
   input logic [PIX_W-1:0]  pix_out,
   input logic              pix_valid,
   input logic              eye_sel,
   input logic              glasses
);
   AST_EYE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (eye_sel != $past(eye_sel)));                       // R2
   AST_EYE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(eye_sel));                                 // R2
   AST_GLASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      glasses == (eye_sel ^ GLASS_INV));                                  // R3
   AST_GLASS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (glasses != $past(glasses)) |-> $past(frame_start));                // R3
   AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_en_left, rd_en_right}));                               // R4
   AST_EN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (rd_en_left != rd_en_right));                            // R4
   AST_ADDR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_start) |-> (rd_addr == '0));                            // R5
   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr < ADDR_W'(H_ACT * V_ACT));                                  // R7
   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid == $past(active, RD_LAT));                                // R8
   AST_ZERO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> (pix_out == '0));                                    // R9
endmodule

bind stereo_interleaver sfi_checker #(
   .H_ACT(H_ACT), .V_ACT(V_ACT), .PIX_W(PIX_W), .RD_LAT(RD_LAT),
   .GLASS_INV(GLASS_INV), .ADDR_W(ADDR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
   .rd_addr(rd_addr), .rd_en_left(rd_en_left), .rd_en_right(rd_en_right),
   .pix_out(pix_out), .pix_valid(pix_valid), .eye_sel(eye_sel),
   .glasses(glasses)
);

// File: tb/stereo_interleaver_tb_top.sv
`timescale 1ns/1ps
module stereo_interleaver_tb_top;
   localparam int unsigned H = 3;
   localparam int unsigned V = 2;
   localparam int unsigned PW = 24;
   localparam int unsigned AW = $clog2(H * V);

   // vector: {frame_start, line_start, active, expected eye, expected addr[3:0]}
   localparam int NV = 22;
   localparam logic [7:0] VEC [NV] = '{
      8'b100_1_0000, 8'b010_0_0000, 8'b001_0_0000, 8'b001_0_0001,
      8'b001_0_0010, 8'b000_0_0000, 8'b010_0_0000, 8'b001_0_0011,
      8'b001_0_0100, 8'b001_0_0101, 8'b000_0_0000,
      8'b100_0_0000, 8'b010_1_0000, 8'b001_1_0000, 8'b001_1_0001,
      8'b001_1_0010, 8'b000_1_0000, 8'b010_1_0000, 8'b001_1_0011,
      8'b001_1_0100, 8'b001_1_0101, 8'b000_1_0000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fs = 1'b0, ls = 1'b0, act = 1'b0;
   logic [PW-1:0] l_data, r_data;
   logic [AW-1:0] rd_addr;
   logic en_l, en_r, pv, eye, gl;
   logic [PW-1:0] pix;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   function automatic logic [PW-1:0] store_word(input logic right, input int a);
      return {right ? 8'hEE : 8'h11, 16'(a)};
   endfunction

   always_ff @(posedge clk) begin
      l_data <= store_word(1'b0, int'(rd_addr));
      r_data <= store_word(1'b1, int'(rd_addr));
   end

   stereo_interleaver #(.H_ACT(H), .V_ACT(V), .PIX_W(PW), .RD_LAT(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .line_start(ls), .active(act),
      .left_rd_data(l_data), .right_rd_data(r_data), .rd_addr(rd_addr),
      .rd_en_left(en_l), .rd_en_right(en_r), .pix_out(pix), .pix_valid(pv),
      .eye_sel(eye), .glasses(gl)
   );

   task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
      end
   endtask

   task automatic step(input logic f, input logic l, input logic a);
      @(negedge clk);
      fs = f; ls = l; act = a;
      #2;
   endtask

   initial begin
      #(2_000_000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic p_act, p_eye;
      int p_addr;
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      chk(eye == 1'b1, "R1 eye", eye, 1);
      chk(gl == 1'b1, "R1 glasses", gl, 1);
      chk(!en_l && !en_r, "R1 enables", {en_l, en_r}, 0);
      chk(!pv && pix == '0, "R1 pixel", pix, 0);
      @(negedge clk);
      rst_n = 1'b1;

      p_act = 1'b0; p_eye = 1'b0; p_addr = 0;
      for (int i = 0; i < NV; i++) begin
         logic [7:0] v;
         logic [PW-1:0] ep;
         v = VEC[i];
         step(v[7], v[6], v[5]);
         chk(eye == v[4], "R2 eye", eye, v[4]);
         chk(gl == v[4], "R3 glasses", gl, v[4]);
         if (v[5]) begin
            chk(int'(rd_addr) == int'(v[3:0]), "R5 addr", rd_addr, v[3:0]);
            chk(en_l == ~v[4] && en_r == v[4], "R4 enable", {en_l, en_r}, {~v[4], v[4]});
         end else begin
            chk(!en_l && !en_r, "R4 idle enable", {en_l, en_r}, 0);
         end
         ep = p_act ? store_word(p_eye, p_addr) : '0;
         chk(pv == p_act, "R8 valid", pv, p_act);
         chk(pix == ep, p_act ? "R8 pixel" : "R9 blank", pix, ep);
         p_act = v[5]; p_eye = v[4]; p_addr = int'(v[3:0]);
      end

      // R6: empty line does not advance row
      step(1, 0, 0);
      chk(eye == 1'b1, "R2 before toggle", eye, 1);
      step(0, 1, 0);
      chk(eye == 1'b0 && gl == 1'b0, "R3 glasses at frame", gl, 0);
      step(0, 1, 0);
      step(0, 0, 1);
      chk(rd_addr == 0, "R6 empty line", rd_addr, 0);
      // R7: column clamp
      step(0, 0, 1);
      chk(rd_addr == 1, "R5 col step", rd_addr, 1);
      step(0, 0, 1);
      step(0, 0, 1);
      chk(rd_addr == 2, "R7 col clamp", rd_addr, 2);
      step(0, 0, 0);
      chk(pv && pix == store_word(1'b0, 2), "R8 clamp pixel", pix, store_word(1'b0, 2));
      step(0, 1, 0);
      step(0, 0, 1);
      chk(rd_addr == 3, "R6 row advance", rd_addr, 3);
      step(0, 0, 0);
      step(0, 1, 0);
      step(0, 0, 1);
      chk(rd_addr == 3, "R7 row clamp", rd_addr, 3);
      chk(!gl && !eye, "R3 glasses hold mid-frame", gl, 0);
      // R5: frame start resets mid-frame, R4 right enable
      step(0, 0, 0);
      step(1, 0, 0);
      step(0, 0, 1);
      chk(rd_addr == 0, "R5 frame reset", rd_addr, 0);
      chk(en_r && !en_l, "R4 right enable", {en_l, en_r}, 1);
      step(0, 0, 0);
      chk(pix == store_word(1'b1, 0), "R8 right pixel", pix, store_word(1'b1, 0));
      step(0, 0, 0);
      chk(!pv && pix == '0, "R9 blank after", pix, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule